// File: doc/BRIEF.md
# Fractional-Rate Real-Time Counter

This block keeps a free-running 64-bit time base whose average advance rate is a fixed fraction of its reference clock. Software programs a numerator and a denominator, each a 12-bit field inside a 32-bit register. On every reference clock the numerator is added to a fractional accumulator. When that sum reaches the denominator, the count steps by one and the denominator is taken off the sum. The resulting rate is reference / denominator * numerator. With a 38.4 MHz reference and the reset ratio 4/25 this gives the nominal 6.144 MHz. Other references use other pairs, for example 8/25 at 19.2 MHz, 192/625 at 20 MHz, 64/125 at 12 MHz, 768/1625 at 13 MHz, 384/1625 at 26 MHz and 256/1125 at 27 MHz.

The count feeds processor-local timers directly and is never cleared outside reset. A write to either ratio register restarts the fraction from zero and keeps the count. The upper 20 bits of each ratio register are stored and read back unchanged, so read-modify-write software sees its own data again.

Top module: `rtcFracCounter`

## Requirements
- R1: After reset the count is 0, the numerator register (offset 0x10) reads 0x00000004 and the denominator register (offset 0x14) reads 0x00000019.
- R2: While numerator < denominator, on each clock the numerator (bits 11:0 of the register at 0x10) is added to the fraction. If the sum is at least the denominator (bits 11:0 of the register at 0x14), the count steps by one and the fraction becomes sum minus denominator. Otherwise the fraction becomes the sum.
- R3: From one clock to the next the count either holds or rises by exactly one.
- R4: A write at offset 0x10 stores all 32 data bits, and a read at 0x10 returns them. Only bits 11:0 set the numerator.
- R5: A write at offset 0x14 stores all 32 data bits, and a read at 0x14 returns them. Only bits 11:0 set the denominator.
- R6: A write to either ratio register clears the fraction to zero at that clock edge. On that same edge the count still takes the step that the old ratio calls for.
- R7: A newly written ratio governs stepping from the clock after the write onward.
- R8: While numerator >= denominator (this includes a denominator of 0), the count steps by one on every clock and the fraction stays at zero.
- R9: A write to any offset other than 0x10 and 0x14 changes nothing. A read at such an offset returns 0.
- R10: Starting from a cleared fraction with numerator < denominator, the count rises by exactly the numerator over a span of denominator clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | 8 | Byte offset used for reads and writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| count | output | 64 | Free-running time-base count |

## Verification
A ratio write and a count step can land in the same clock edge. The write clears the fraction, and the step is still decided by the old ratio. The bench sets up a wide ratio, so that a step is certain on every edge, and then writes a smaller numerator. At the write edge the count must still rise by one. From the next edge on, the count must follow the new ratio starting from a fraction of zero. A cycle-by-cycle reference model feeds a queue of expected counts, and every edge is compared against it, which covers the many other coincidences met in the long runs.

// File: rtl/rtcPkg.sv
package rtcPkg;
  typedef struct packed {
    logic clrFrac;
    logic ratioWide;
  } rtcStrobe_t;
endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12,
  parameter logic [ADDR_W-1:0] NUM_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFS = 8'h14,
  parameter int NUM_RST = 4,
  parameter int DEN_RST = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [FRAC_W-1:0] numVal,
  output logic [FRAC_W-1:0] denVal,
  output rtcStrobe_t        strobe
);
  localparam int NREG = 2;

  logic [DATA_W-1:0] regQ [NREG];
  logic [NREG-1:0]   wrHit;
  logic [NREG-1:0]   rdHit;

  for (genvar g = 0; g < NREG; g++) begin : gReg
    localparam logic [ADDR_W-1:0] OFS  = (g == 0) ? NUM_OFS : DEN_OFS;
    localparam logic [DATA_W-1:0] RSTV = (g == 0) ? DATA_W'(NUM_RST) : DATA_W'(DEN_RST);

    assign rdHit[g] = (busAddr == OFS);
    assign wrHit[g] = busWrEn && rdHit[g];

    always_ff @(posedge clk) begin
      if (rst) regQ[g] <= RSTV;
      else if (wrHit[g]) regQ[g] <= busWrData;
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wrHit[g] |=> $stable(regQ[g])); // R9
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NREG; i++)
      if (rdHit[i]) busRdData = regQ[i];
  end

  assign numVal          = regQ[0][FRAC_W-1:0];
  assign denVal          = regQ[1][FRAC_W-1:0];
  assign strobe.clrFrac  = |wrHit;
  assign strobe.ratioWide = (numVal >= denVal);

  AST_NUM_STORE: assert property (@(posedge clk) disable iff (rst)
    wrHit[0] |=> (regQ[0] == $past(busWrData))); // R4
  AST_DEN_STORE: assert property (@(posedge clk) disable iff (rst)
    wrHit[1] |=> (regQ[1] == $past(busWrData))); // R5
endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtcPkg::*;
#(
  parameter int FRAC_W  = 12,
  parameter int COUNT_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAC_W-1:0]  numVal,
  input  logic [FRAC_W-1:0]  denVal,
  input  rtcStrobe_t         strobe,
  output logic [COUNT_W-1:0] count
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0]  fracQ, fracNext;
  logic [SUM_W-1:0]   sum;
  logic               step;
  logic [COUNT_W-1:0] countQ;

  always_comb begin
    sum = {1'b0, fracQ} + {1'b0, numVal};
    if (strobe.ratioWide) begin
      step     = 1'b1;
      fracNext = '0;
    end else if (sum >= {1'b0, denVal}) begin
      step     = 1'b1;
      fracNext = FRAC_W'(sum - {1'b0, denVal});
    end else begin
      step     = 1'b0;
      fracNext = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fracQ  <= '0;
      countQ <= '0;
    end else begin
      fracQ  <= strobe.clrFrac ? '0 : fracNext;
      countQ <= countQ + COUNT_W'(step);
    end
  end

  assign count = countQ;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (countQ == $past(countQ)) || (countQ == $past(countQ) + 1'b1)); // R3
  AST_FRAC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (fracQ == '0) || (fracQ < denVal)); // R2
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    strobe.clrFrac |=> (fracQ == '0)); // R6
  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.ratioWide |=> (countQ == $past(countQ) + 1'b1)); // R8
endmodule

// File: rtl/rtcFracCounter.sv
module rtcFracCounter
  import rtcPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 12,
  parameter int COUNT_W = 64,
  parameter logic [ADDR_W-1:0] NUM_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] DEN_OFS = 8'h14,
  parameter int NUM_RST = 4,
  parameter int DEN_RST = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic [COUNT_W-1:0] count
);
  logic [FRAC_W-1:0] numVal, denVal;
  rtcStrobe_t        strobe;

  rtcCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W),
    .NUM_OFS(NUM_OFS), .DEN_OFS(DEN_OFS),
    .NUM_RST(NUM_RST), .DEN_RST(DEN_RST)
  ) uCtrl (
    .clk(clk), .rst(rst),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData),
    .numVal(numVal), .denVal(denVal), .strobe(strobe)
  );

  rtcDatapath #(.FRAC_W(FRAC_W), .COUNT_W(COUNT_W)) uPath (
    .clk(clk), .rst(rst),
    .numVal(numVal), .denVal(denVal), .strobe(strobe),
    .count(count)
  );
endmodule

// File: tb/sim_rtcFracCounter.sv
module sim_rtcFracCounter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [63:0] expQ[$];

  // model state
  logic [31:0] mNum, mDen;
  int          mAcc;
  logic [63:0] mCnt;

  always #4 clk = ~clk;

  rtcFracCounter u0 (
    .clk(clk), .rst(rst), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .count(count)
  );

  // driver-side reference model: pushes the expected count for each edge
  always @(posedge clk) begin
    if (rst) begin
      mNum = 32'd4; mDen = 32'd25; mAcc = 0; mCnt = '0;
    end else begin
      int n, d, s;
      n = int'(mNum[11:0]); d = int'(mDen[11:0]);
      if (n >= d) begin
        mCnt = mCnt + 1; mAcc = 0;
      end else begin
        s = mAcc + n;
        if (s >= d) begin mCnt = mCnt + 1; mAcc = s - d; end
        else mAcc = s;
      end
      if (busWrEn && busAddr == 8'h10) begin mNum = busWrData; mAcc = 0; end
      if (busWrEn && busAddr == 8'h14) begin mDen = busWrData; mAcc = 0; end
      expQ.push_back(mCnt);
    end
  end

  // monitor: compares the count against the queue on every cycle
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [63:0] e;
      e = expQ.pop_front();
      total++;
      if (count !== e) begin
        bad++;
        $display("FAIL R2/R3 scoreboard: count act=%0d exp=%0d", count, e);
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 8'h00; busWrData = '0;
  endtask

  task automatic rdChk(string tag, logic [7:0] a, logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, 64'(busRdData), 64'(exp));
    busAddr = 8'h00;
  endtask

  task automatic spanChk(string tag, int clocks, logic [63:0] delta);
    logic [63:0] c0;
    c0 = count;
    repeat (clocks) @(negedge clk);
    check(tag, count - c0, delta);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 count", count, 64'd0);
    rdChk("R1 num reg", 8'h10, 32'h0000_0004);
    rdChk("R1 den reg", 8'h14, 32'h0000_0019);
    // R10 default ratio over one denominator span
    spanChk("R10 4/25", 25, 64'd4);
    // R4 numerator write keeps upper bits, R7 new ratio next cycle
    wr(8'h10, 32'hABCD_E008);
    rdChk("R4 num readback", 8'h10, 32'hABCD_E008);
    spanChk("R7 8/25", 25, 64'd8);
    // R5 denominator write keeps upper bits
    wr(8'h14, 32'h1234_5003);
    rdChk("R5 den readback", 8'h14, 32'h1234_5003);
    // R8 wide ratio 8/3: one step per clock
    spanChk("R8 wide", 10, 64'd10);
    // R6 coincidence: write on an edge that steps under the old ratio
    begin
      logic [63:0] c0;
      c0 = count;
      wr(8'h10, 32'h0000_0001);
      check("R6 step on write edge", count, c0 + 64'd1);
      spanChk("R6 fraction restarts 1/3", 3, 64'd1);
    end
    // R8 zero denominator
    wr(8'h14, 32'h0000_0000);
    spanChk("R8 den zero", 7, 64'd7);
    // R9 stray offsets
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rdChk("R9 read stray", 8'h18, 32'h0);
    rdChk("R9 num unchanged", 8'h10, 32'h0000_0001);
    rdChk("R9 den unchanged", 8'h14, 32'h0000_0000);
    // R10 13 MHz pair
    wr(8'h14, 32'h0000_0659);
    wr(8'h10, 32'h0000_0300);
    spanChk("R10 768/1625", 1625, 64'd768);
    // R2 largest numerator below denominator
    wr(8'h14, 32'h0000_0FFF);
    wr(8'h10, 32'h0000_0FFE);
    spanChk("R2 4094/4095", 4095, 64'd4094);
    // R10 27 MHz pair, upper bits set in both
    wr(8'h14, 32'hFFFF_F465);
    wr(8'h10, 32'hFFFF_F100);
    spanChk("R10 256/1125", 1125, 64'd256);
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule